// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver with Two-Entry Queue

This block recovers characters from an asynchronous serial line. A tick arriving at sixteen times the bit rate drives a recovery state machine. The machine finds a start bit, confirms it at mid-bit, and decides each data bit and the stop bit by a majority vote of three samples around the bit centre. It assembles eight data bits, or nine when the nine-bit enable is set, least significant bit first. Each finished character goes into a two-entry first-in first-out queue, together with its framing status. The host reads that queue through a pop strobe.

Two complete characters can wait in the queue while a third is being received. If a character completes while both entries are occupied, it is dropped and a sticky overrun flag is raised. Reception then stays blocked until continuous receive is turned off. The line input passes through a two-flop synchronizer before the state machine sees it.

The recovery state machine has four states:
- `RX_IDLE` moves to `RX_START` on a tick whose sample is low when the previous sample was high.
- `RX_START` returns to `RX_IDLE` if the mid-bit check sees a high line, and moves to `RX_DATA` if it sees a low line.
- `RX_DATA` moves to `RX_STOP` after the vote on the last data bit.
- `RX_STOP` delivers the character at the stop-bit vote and returns to `RX_IDLE`.
- Every state falls back to `RX_IDLE` whenever reception is not running.

Top module: `uart_os_rx`

## Requirements
- R1: Characters are received only while port_en=1, cont_rx=1 and sync_mode=0. A frame sent while any of these conditions fails leaves data_avail low.
- R2: A start is recognised only on a high-to-low change between two tick samples, and only if the line is still low at the mid-bit check. A low pulse shorter than half a bit is discarded.
- R3: Data bits arrive least significant bit first. Each bit is the majority of three tick samples at the bit centre, so one corrupted sample does not change the bit.
- R4: A character has 8 data bits when nine_bit_en=0 and 9 data bits when nine_bit_en=1. The ninth bit appears on rd_bit8, which reads 0 for 8-bit characters.
- R5: A character is written into the two-entry queue at the stop-bit vote. Up to two characters are held, in arrival order.
- R6: rd_data, rd_bit8 and frame_err show the oldest queue entry. A one-cycle rd_pop removes that entry. A pop while the queue is empty does nothing.
- R7: data_avail is 1 exactly when the queue holds one or more entries.
- R8: A character whose stop-bit vote is 0 is stored with frame_err=1. The flag travels with that entry only.
- R9: When a character completes with both entries full, it is discarded and overrun_err becomes 1. The flag stays set and further frames are ignored until cont_rx=0, which clears it. Queued entries are kept.
- R10: port_en=0 empties the queue and clears overrun_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial line, idle high |
| tick16 | input | 1 | One-cycle pulse at sixteen times the bit rate |
| port_en | input | 1 | Serial port enable |
| cont_rx | input | 1 | Continuous receive enable; 0 clears overrun |
| sync_mode | input | 1 | Synchronous mode select; receiver idles when 1 |
| nine_bit_en | input | 1 | Selects 9 data bits per character |
| rd_pop | input | 1 | Removes the oldest queue entry |
| rd_data | output | 8 | Low eight bits of the oldest entry |
| rd_bit8 | output | 1 | Ninth bit of the oldest entry |
| data_avail | output | 1 | Queue not empty |
| frame_err | output | 1 | Framing error of the oldest entry |
| overrun_err | output | 1 | Sticky overrun flag |

## Verification
The bench sends a low glitch shorter than half a bit. A receiver that skipped the mid-bit confirmation would store a spurious character. It also flips the middle vote sample of a data bit, which exposes a receiver that takes a single sample or votes at the wrong phase.

A third character is sent with the queue full, and a fourth while blocked, even after a pop has freed a slot. A design that overwrote an entry, or resumed before cont_rx was cleared, would show the wrong head or an extra entry. Framing errors, ninth bits, pops on an empty queue and a port-disable flush are mixed into seeded random traffic. A design that let a flag leak between entries, or mishandled the nine-bit setting, would mismatch the bench's queue model.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic       ferr;
        logic [8:0] data;
    } rx_entry_t;
endpackage

// File: rtl/uart_rx_recover.sv
module uart_rx_recover
    import uart_rx_pkg::*;
#(
    parameter int OSR      = 16,
    parameter int MAX_BITS = 9
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run,
    input  logic      tick,
    input  logic      rx_s,
    input  logic      nine_bit,
    output logic      char_valid,
    output rx_entry_t char_out
);
    localparam int CW = $clog2(OSR);
    localparam int BW = $clog2(MAX_BITS + 1);
    localparam logic [CW-1:0] START_CHK = CW'(OSR / 2 - 2);
    localparam logic [CW-1:0] RELOAD    = CW'(OSR / 2 + 2);
    localparam logic [CW-1:0] VOTE_A    = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] VOTE_B    = CW'(OSR / 2);
    localparam logic [CW-1:0] VOTE_C    = CW'(OSR / 2 + 1);
    localparam logic [CW-1:0] CNT_TOP   = CW'(OSR - 1);

    rx_state_e         state, nxt;
    logic [CW-1:0]     cnt;
    logic [BW-1:0]     bit_idx;
    logic [MAX_BITS-1:0] sr;
    logic              vote_a, vote_b, prev;
    logic              maj, last_bit;

    assign maj      = (vote_a & vote_b) | (vote_a & rx_s) | (vote_b & rx_s);
    assign last_bit = (bit_idx == (nine_bit ? BW'(8) : BW'(7)));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= RX_IDLE;
        else if (!run)
            state <= RX_IDLE;
        else
            state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:  if (tick && prev && !rx_s) nxt = RX_START;
            RX_START: if (tick && cnt == START_CHK) nxt = rx_s ? RX_IDLE : RX_DATA;
            RX_DATA:  if (tick && cnt == VOTE_C && last_bit) nxt = RX_STOP;
            RX_STOP:  if (tick && cnt == VOTE_C) nxt = RX_IDLE;
            default:  nxt = RX_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt        <= '0;
            bit_idx    <= '0;
            sr         <= '0;
            vote_a     <= 1'b1;
            vote_b     <= 1'b1;
            prev       <= 1'b1;
            char_valid <= 1'b0;
            char_out   <= '0;
        end else begin
            char_valid <= 1'b0;
            if (!run) begin
                cnt     <= '0;
                bit_idx <= '0;
                prev    <= rx_s;
            end else if (tick) begin
                unique case (state)
                    RX_IDLE: begin
                        prev    <= rx_s;
                        cnt     <= '0;
                        bit_idx <= '0;
                        sr      <= '0;
                    end
                    RX_START: begin
                        if (cnt == START_CHK) begin
                            cnt  <= RELOAD;
                            prev <= rx_s;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_DATA, RX_STOP: begin
                        cnt <= (cnt == CNT_TOP) ? '0 : cnt + 1'b1;
                        if (cnt == VOTE_A) vote_a <= rx_s;
                        if (cnt == VOTE_B) vote_b <= rx_s;
                        if (cnt == VOTE_C) begin
                            if (state == RX_DATA) begin
                                sr[bit_idx] <= maj;
                                bit_idx     <= bit_idx + 1'b1;
                            end else begin
                                char_valid    <= 1'b1;
                                char_out.ferr <= ~maj;
                                char_out.data <= nine_bit ? sr : {1'b0, sr[7:0]};
                                prev          <= maj;
                            end
                        end
                    end
                    default: cnt <= '0;
                endcase
            end
        end
    end

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> state == RX_IDLE); // R1
    AST_BIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        state == RX_DATA |-> bit_idx <= BW'(8)); // R4
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |=> !char_valid); // R5
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      flush,
    input  logic      push,
    input  rx_entry_t push_data,
    input  logic      pop,
    output rx_entry_t head,
    output logic      full,
    output logic      empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CTW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    rx_entry_t      mem [DEPTH];
    logic [PW-1:0]  wr_ptr, rd_ptr;
    logic [CTW-1:0] count;
    logic           do_push, do_pop;

    assign full    = (count == CTW'(DEPTH));
    assign empty   = (count == '0);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    mem[i] <= '0;
                else if (do_push && !flush && wr_ptr == PW'(i))
                    mem[i] <= push_data;
            end
        end
    endgenerate

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CTW'(DEPTH)); // R5
    AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push && !flush) |=> empty); // R6
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> full); // R9
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
    import uart_rx_pkg::*;
#(
    parameter int OSR        = 16,
    parameter int FIFO_DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_line,
    input  logic       tick16,
    input  logic       port_en,
    input  logic       cont_rx,
    input  logic       sync_mode,
    input  logic       nine_bit_en,
    input  logic       rd_pop,
    output logic [7:0] rd_data,
    output logic       rd_bit8,
    output logic       data_avail,
    output logic       frame_err,
    output logic       overrun_err
);
    logic      sync1, sync2;
    logic      run, char_valid, full, empty, ovr;
    rx_entry_t char_out, head;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
        end else begin
            sync1 <= rx_line;
            sync2 <= sync1;
        end
    end

    assign run = port_en && cont_rx && !sync_mode && !ovr;

    uart_rx_recover #(.OSR(OSR), .MAX_BITS(9)) u_recover (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .tick       (tick16),
        .rx_s       (sync2),
        .nine_bit   (nine_bit_en),
        .char_valid (char_valid),
        .char_out   (char_out)
    );

    uart_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (!port_en),
        .push      (char_valid),
        .push_data (char_out),
        .pop       (rd_pop),
        .head      (head),
        .full      (full),
        .empty     (empty)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ovr <= 1'b0;
        else if (!port_en || !cont_rx)
            ovr <= 1'b0;
        else if (char_valid && full && !rd_pop)
            ovr <= 1'b1;
    end

    assign rd_data     = head.data[7:0];
    assign rd_bit8     = head.data[8];
    assign frame_err   = head.ferr;
    assign data_avail  = !empty;
    assign overrun_err = ovr;

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && cont_rx && port_en) |=> ovr); // R9
    AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !cont_rx |=> !ovr); // R9
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> !data_avail); // R10
endmodule

// File: tb/tb_uart_os_rx.sv
`timescale 1ns/1ps
module tb_uart_os_rx;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_line = 1'b1, tick16 = 1'b0;
    logic port_en = 1'b1, cont_rx = 1'b1, sync_mode = 1'b0, nine_bit_en = 1'b0;
    logic rd_pop = 1'b0;
    logic [7:0] rd_data;
    logic rd_bit8, data_avail, frame_err, overrun_err;

    always #2.5 clk = ~clk;

    uart_os_rx dut (.*);

    int n_chk = 0, n_fail = 0;
    logic [9:0] m_q [2];
    int   m_n = 0;
    bit   m_ovr = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit rx_on();
        return port_en && cont_rx && !sync_mode;
    endfunction

    task automatic model_char(input logic [8:0] d, input bit stp);
        if (!rx_on() || m_ovr) return;
        if (m_n == 2) begin m_ovr = 1; return; end
        m_q[m_n] = {~stp, nine_bit_en ? d : {1'b0, d[7:0]}};
        m_n++;
    endtask

    task automatic chunk(input logic v);
        @(negedge clk); rx_line = v; tick16 = 1'b1;
        @(negedge clk); tick16 = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_bit(input logic v, input bit gl);
        for (int i = 0; i < 16; i++) chunk((gl && i == 6) ? ~v : v);
    endtask

    task automatic send_char(input logic [8:0] d, input bit stp, input int gl);
        send_bit(1'b0, 0);
        for (int k = 0; k < (nine_bit_en ? 9 : 8); k++) send_bit(d[k], gl == k);
        send_bit(stp, 0);
        send_bit(1'b1, 0);
        send_bit(1'b1, 0);
        model_char(d, stp);
    endtask

    task automatic check_state(input string tag);
        chk(data_avail == (m_n != 0), {"R7 ", tag}, data_avail, m_n != 0);
        chk(overrun_err == m_ovr, {"R9 ", tag}, overrun_err, m_ovr);
        if (m_n > 0) begin
            chk(rd_data == m_q[0][7:0], {"R6/R3 ", tag}, rd_data, m_q[0][7:0]);
            chk(rd_bit8 == m_q[0][8], {"R4 ", tag}, rd_bit8, m_q[0][8]);
            chk(frame_err == m_q[0][9], {"R8 ", tag}, frame_err, m_q[0][9]);
        end
    endtask

    task automatic do_pop(input string tag);
        check_state(tag);
        @(negedge clk); rd_pop = 1'b1;
        @(negedge clk); rd_pop = 1'b0;
        if (m_n > 0) begin m_q[0] = m_q[1]; m_n--; end
        check_state({tag, " after pop R6"});
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h1F2E3D4C));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_state("reset");

        // R1: sync mode blocks reception
        sync_mode = 1'b1;
        send_char(9'h0C3, 1, -1);
        check_state("R1 sync_mode");
        sync_mode = 1'b0;
        cont_rx = 1'b0;
        send_char(9'h0C3, 1, -1);
        cont_rx = 1'b1;
        check_state("R1 cont_rx off");

        // R2: short low pulse rejected
        for (int i = 0; i < 5; i++) chunk(1'b0);
        for (int i = 0; i < 40; i++) chunk(1'b1);
        check_state("R2 glitch");

        // R3/R4/R5: two characters, one with a corrupted middle sample
        send_char(9'h0A5, 1, -1);
        check_state("R5 first");
        send_char(9'h03C, 1, 2);
        check_state("R3 second");

        // R9: overrun, blocked after pop
        send_char(9'h0FF, 1, -1);
        check_state("R9 overrun");
        do_pop("R9 pop while blocked");
        send_char(9'h011, 1, -1);
        check_state("R9 still blocked");
        cont_rx = 1'b0; @(negedge clk); @(negedge clk); m_ovr = 0;
        cont_rx = 1'b1;
        check_state("R9 cleared");
        do_pop("R5 order");
        do_pop("R6 empty pop");

        // R4 nine bits, R8 framing
        nine_bit_en = 1'b1;
        send_char(9'h1F0, 1, -1);
        send_char(9'h055, 0, -1);
        do_pop("R4 ninth");
        do_pop("R8 framing");
        nine_bit_en = 1'b0;

        // R10 flush
        send_char(9'h099, 1, -1);
        check_state("R10 before");
        port_en = 1'b0; @(negedge clk); @(negedge clk);
        m_n = 0; m_ovr = 0;
        check_state("R10 flushed");
        port_en = 1'b1;

        // random traffic
        for (int it = 0; it < 40; it++) begin
            logic [8:0] d;
            bit stp;
            int gl, np;
            nine_bit_en = ($urandom_range(0, 3) == 0);
            d   = 9'($urandom);
            stp = ($urandom_range(0, 7) != 0);
            gl  = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 7) : -1;
            send_char(d, stp, gl);
            check_state("rand R5");
            if (m_ovr && $urandom_range(0, 1) == 1) begin
                cont_rx = 1'b0; @(negedge clk); @(negedge clk); m_ovr = 0;
                cont_rx = 1'b1;
                check_state("rand R9 clear");
            end
            np = $urandom_range(0, 2);
            for (int p = 0; p < np; p++) do_pop("rand R6");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule